// File: doc/BRIEF.md
# Serial Receive Channel with Per-Character Error Queue

This block is the receive half of an asynchronous serial port. A 16x oversampling front end picks characters off the line: each start, data, optional parity, optional multiprocessor flag and stop bit is sampled at mid-bit. The result goes into a queue that is four characters deep. Beside every queued byte sits a four-bit error tag that holds its parity error, framing error, break indication and multiprocessor flag. An overrun is recorded in a separate sticky flag rather than in any tag.

The read side is a valid/ready stream. `rx_valid` is high whenever the queue holds a character. `rx_data` and the four error pins always show the head entry. A transfer happens on a clock edge where `rx_valid` and `rx_ready` are both high, and it removes the byte and its tag together. Holding `rx_ready` low leaves the head in place indefinitely. Characters that finish while the queue is full are dropped and raise the overrun flag.

A control register holds the receive and transmit enables and the line format. Two conditions force the channel into a cleared state for as long as they last: a stop request, and an inactive carrier while carrier auto-enable is selected. In that state the queue, its tags and the overrun flag are emptied, and both enables are forced off.

Top module: `uart_rx_chan`

## Requirements
- R1: Characters leave the read stream in arrival order; `rx_valid` is high exactly while the 4-entry queue is non-empty, and one entry is removed per edge with `rx_valid` and `rx_ready` both high.
- R2: The error pins `rx_perr`, `rx_ferr`, `rx_brk` and `rx_mpb` always show the tag stored with the character currently on `rx_data`.
- R3: A character that completes while four entries are held is discarded and sets `ovr_flag`. The flag clears only on a transfer that follows a `stat_rd` strobe, or on a forced clear.
- R4: While `io_stop` is high, the queue is empty, all tags and `ovr_flag` are cleared, and control bits 6 (receive enable) and 5 (transmit enable) read 0.
- R5: While `dcd_auto` is 1 and `dcd_n` is 1, the channel is held in the same cleared state as in R4.
- R6: While `dcd_auto` is 0, `dcd_n` has no effect on reception, the queue or the enables.
- R7: Control bit 4 enables a parity bit after the data, and bit 3 selects odd (1) or even (0) parity. A mismatch sets `rx_perr`. With parity disabled, `rx_perr` is 0.
- R8: A character whose stop bit samples low has `rx_ferr` set.
- R9: A frame whose data, parity, multiprocessor and stop bits all sample low is stored with data 0x00, `rx_brk` = 1 and `rx_ferr` = 1.
- R10: Control bit 2 adds a multiprocessor bit after the data (and after parity, if parity is on). Its value is stored with the character and shown on `rx_mpb`. With the mode off, `rx_mpb` is 0.
- R11: A start bit is confirmed by a sample on the eighth oversampling tick. A low pulse of fewer than eight ticks produces no character.
- R12: With control bit 6 clear, line activity produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idles high |
| io_stop | input | 1 | Stop request, forces the cleared state |
| dcd_n | input | 1 | Carrier detect, active low |
| dcd_auto | input | 1 | Selects carrier auto-enable |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value (bit6 rx en, bit5 tx en, bit4 parity en, bit3 odd, bit2 mp mode) |
| ctl_q | output | 8 | Control register contents |
| rx_valid | output | 1 | Queue holds a character |
| rx_ready | input | 1 | Consumer takes the head this edge |
| rx_data | output | 8 | Head character |
| rx_perr | output | 1 | Head parity error |
| rx_ferr | output | 1 | Head framing error |
| rx_brk | output | 1 | Head break |
| rx_mpb | output | 1 | Head multiprocessor bit |
| stat_rd | input | 1 | Status-read strobe that arms the overrun clear |
| ovr_flag | output | 1 | Overrun latch |

## Verification
The line input passes through two synchronizer stages. The stop bit is sampled on the sixteenth tick after the previous sample, and the completion pulse registers at that edge. The entry is visible on `rx_valid` one edge after that. The bench therefore waits two full bit periods of idle line after each stop bit before it looks at the read side. Forced clears and control writes take effect on the first edge, and transfers and overrun clearing show on the edge where the handshake happens. All samples are taken on the falling clock edge after those rising edges.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  // control register bit positions
  localparam int CTL_RXEN = 6;
  localparam int CTL_TXEN = 5;
  localparam int CTL_PEN  = 4;
  localparam int CTL_PODD = 3;
  localparam int CTL_MPEN = 2;

  typedef struct packed {
    logic perr;
    logic ferr;
    logic brk;
    logic mpb;
  } rx_tag_t;

  localparam int TAG_W = $bits(rx_tag_t);

  typedef enum logic [1:0] {
    S_IDLE,
    S_START,
    S_BITS,
    S_WAIT
  } samp_st_t;
endpackage

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign rdata = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= wdata;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rx_sampler.sv
module rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mp_en,
  output logic              done,
  output logic [DATA_W-1:0] char_q,
  output rx_tag_t           tag_q
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int FW   = DATA_W + 2;
  localparam int BW   = $clog2(FW + 2);

  samp_st_t      st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx, nbits;
  logic [FW-1:0] frame;
  logic [1:0]    sync;
  logic          rxd_s;

  assign rxd_s = sync[1];
  assign nbits = BW'(DATA_W) + BW'(par_en) + BW'(mp_en);

  // decode of the completed frame; stop bit is the live sample
  logic [DATA_W-1:0] d_w;
  logic              pbit, mbit, stop_b;
  rx_tag_t           tag_w;
  always_comb begin
    d_w    = frame[DATA_W-1:0];
    pbit   = frame[DATA_W];
    mbit   = par_en ? frame[DATA_W+1] : frame[DATA_W];
    stop_b = rxd_s;
    tag_w.perr = par_en & (^d_w ^ pbit ^ par_odd);
    tag_w.ferr = ~stop_b;
    tag_w.brk  = (d_w == '0) & ~(par_en & pbit) & ~(mp_en & mbit) & ~stop_b;
    tag_w.mpb  = mp_en & mbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      frame  <= '0;
      done   <= 1'b0;
      char_q <= '0;
      tag_q  <= '0;
    end else begin
      done <= 1'b0;
      if (clr || !en) begin
        st   <= S_IDLE;
        cnt  <= '0;
        bidx <= '0;
      end else if (tick) begin
        case (st)
          S_IDLE: if (!rxd_s) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
          S_START: if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= rxd_s ? S_IDLE : S_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
          S_BITS: if (cnt == CW'(OSR - 1)) begin
            cnt <= '0;
            if (bidx == nbits) begin
              done   <= 1'b1;
              char_q <= d_w;
              tag_q  <= tag_w;
              st     <= S_WAIT;
            end else begin
              frame[bidx] <= rxd_s;
              bidx        <= bidx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          default: if (rxd_s) st <= S_IDLE;
        endcase
      end
    end
  end

  p_start_mid_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BITS && $past(st) == S_START) |-> !$past(rxd_s));
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/uart_rx_chan.sv
module uart_rx_chan
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              io_stop,
  input  logic              dcd_n,
  input  logic              dcd_auto,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_q,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_brk,
  output logic              rx_mpb,
  input  logic              stat_rd,
  output logic              ovr_flag
);
  logic              clr, done, pop, push;
  logic              d_empty, d_full, t_empty, t_full;
  logic [DATA_W-1:0] char_w;
  rx_tag_t           tag_w, tag_h;
  logic [7:0]        ctl;
  logic              armed;

  assign clr = io_stop | (dcd_auto & dcd_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (ctl_we) ctl <= ctl_wdata;
      if (clr) begin
        ctl[CTL_RXEN] <= 1'b0;
        ctl[CTL_TXEN] <= 1'b0;
      end
    end
  end
  assign ctl_q = ctl;

  rx_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_samp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(ctl[CTL_RXEN]),
    .tick(baud_tick), .rxd(rxd),
    .par_en(ctl[CTL_PEN]), .par_odd(ctl[CTL_PODD]), .mp_en(ctl[CTL_MPEN]),
    .done(done), .char_q(char_w), .tag_q(tag_w)
  );

  assign push = done & ~d_full & ~clr;
  assign pop  = rx_valid & rx_ready & ~clr;

  rx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_dfifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .wdata(char_w),
    .pop(pop), .rdata(rx_data), .empty(d_empty), .full(d_full)
  );

  rx_fifo #(.W(TAG_W), .DEPTH(DEPTH)) u_tfifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .wdata(tag_w),
    .pop(pop), .rdata(tag_h), .empty(t_empty), .full(t_full)
  );

  assign rx_valid = ~d_empty;
  assign rx_perr  = tag_h.perr & rx_valid;
  assign rx_ferr  = tag_h.ferr & rx_valid;
  assign rx_brk   = tag_h.brk  & rx_valid;
  assign rx_mpb   = tag_h.mpb  & rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      armed    <= 1'b0;
    end else if (clr) begin
      ovr_flag <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (stat_rd && ovr_flag) armed <= 1'b1;
      if (pop && armed) begin
        ovr_flag <= 1'b0;
        armed    <= 1'b0;
      end
      if (done && d_full) ovr_flag <= 1'b1;
    end
  end

  p_pair_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (d_empty == t_empty) && (d_full == t_full));
  p_clear_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!rx_valid && !ovr_flag && !ctl_q[CTL_RXEN] && !ctl_q[CTL_TXEN]));
  p_ovr_on_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && d_full && !clr) |=> ovr_flag);
  p_brk_ferr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |-> rx_ferr);
  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr && !pop) |=> ovr_flag);
endmodule

// File: tb/tb_uart_rx_chan.sv
module tb_uart_rx_chan;
  logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, rxd = 1'b1;
  logic       io_stop = 1'b0, dcd_n = 1'b0, dcd_auto = 1'b0;
  logic       ctl_we = 1'b0, rx_ready = 1'b0, stat_rd = 1'b0;
  logic [7:0] ctl_wdata = '0, ctl_q, rx_data;
  logic       rx_valid, rx_perr, rx_ferr, rx_brk, rx_mpb, ovr_flag;
  int         checks = 0, errors = 0;
  logic       finished = 1'b0;
  logic [1:0] tdiv = '0;

  always #2 clk = ~clk;

  // 16x tick every 4 clocks: one bit = 64 clocks
  always @(posedge clk) begin
    tdiv      <= tdiv + 1'b1;
    baud_tick <= (tdiv == 2'd3);
  end

  uart_rx_chan dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .io_stop(io_stop), .dcd_n(dcd_n), .dcd_auto(dcd_auto),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_mpb(rx_mpb),
    .stat_rd(stat_rd), .ovr_flag(ovr_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic pop_one();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic strobe_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic line_bit(input logic b);
    rxd = b;
    repeat (64) @(negedge clk);
  endtask

  // sends start, data LSB first, [parity], [mp bit], stop, then idle
  task automatic send(input logic [7:0] d, input logic pen, input logic podd,
                      input logic men, input logic mb, input logic badp,
                      input logic stopv);
    logic p;
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(d[i]);
    p = (^d) ^ podd ^ badp;
    if (pen) line_bit(p);
    if (men) line_bit(mb);
    line_bit(stopv);
    rxd = 1'b1;
    repeat (128) @(negedge clk);
  endtask

  task automatic expect_head(input string req, input logic [7:0] d,
                             input logic [3:0] tag);
    chk({req, " valid"}, rx_valid, 1'b1);
    chk({req, " data"}, rx_data, d);
    chk({req, " tag"}, {rx_perr, rx_ferr, rx_brk, rx_mpb}, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [5];
    vals = '{8'h01, 8'h55, 8'hA3, 8'hFF, 8'h80};
    repeat (3) @(negedge clk);
    // reset state
    chk("R4 reset valid", rx_valid, 1'b0);
    chk("R4 reset ctl", ctl_q, 8'h00);
    chk("R3 reset ovr", ovr_flag, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12: receiver disabled ignores the line
    send(8'h3C, 0, 0, 0, 0, 0, 1);
    chk("R12 disabled no char", rx_valid, 1'b0);

    // sweep: parity off/even/odd x mp off/on x data values (R7 R10 R1 R2)
    for (int cfg = 0; cfg < 6; cfg++) begin
      logic pen, podd, men;
      pen  = (cfg % 3) != 0;
      podd = (cfg % 3) == 2;
      men  = cfg >= 3;
      wr_ctl({1'b0, 1'b1, 1'b0, pen, podd, men, 2'b00});
      for (int i = 0; i < 5; i++) begin
        logic badp, mb;
        badp = (i == 2);
        mb   = i[0];
        send(vals[i], pen, podd, men, mb, badp, 1);
        expect_head("R7 R10 R2 sweep", vals[i], {pen & badp, 1'b0, 1'b0, men & mb});
        pop_one();
        chk("R1 empty after pop", rx_valid, 1'b0);
      end
    end

    // R1 R3: order and overrun
    wr_ctl(8'h40);
    for (int i = 0; i < 5; i++) send(8'h10 + 8'(i), 0, 0, 0, 0, 0, 1);
    chk("R3 overrun set", ovr_flag, 1'b1);
    pop_one();
    chk("R3 pop without status read keeps flag", ovr_flag, 1'b1);
    strobe_stat();
    chk("R3 status read alone keeps flag", ovr_flag, 1'b1);
    expect_head("R1 order", 8'h11, 4'b0000);
    pop_one();
    chk("R3 flag cleared by read then pop", ovr_flag, 1'b0);
    expect_head("R1 order", 8'h12, 4'b0000);
    pop_one();
    expect_head("R1 order last kept", 8'h13, 4'b0000);
    pop_one();
    chk("R3 fifth char discarded", rx_valid, 1'b0);

    // R8 framing error, R9 break
    send(8'h5A, 0, 0, 0, 0, 0, 0);
    expect_head("R8 framing", 8'h5A, 4'b0100);
    pop_one();
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < 9; i++) line_bit(1'b0);
    rxd = 1'b1;
    repeat (128) @(negedge clk);
    expect_head("R9 break", 8'h00, 4'b0110);
    pop_one();
    chk("R9 single entry", rx_valid, 1'b0);

    // R11 short start pulse rejected
    @(negedge clk);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (256) @(negedge clk);
    chk("R11 glitch no char", rx_valid, 1'b0);
    send(8'hC3, 0, 0, 0, 0, 0, 1);
    expect_head("R11 valid start after glitch", 8'hC3, 4'b0000);
    pop_one();

    // R6 dcd ignored without auto-enable
    wr_ctl(8'h60);
    dcd_n = 1'b1;
    send(8'h77, 0, 0, 0, 0, 0, 1);
    expect_head("R6 dcd ignored", 8'h77, 4'b0000);
    chk("R6 enables kept", ctl_q[6:5], 2'b11);

    // R5 auto-enable with carrier lost
    @(negedge clk); dcd_auto = 1'b1;
    @(negedge clk);
    chk("R5 fifo emptied", rx_valid, 1'b0);
    chk("R5 enables cleared", ctl_q[6:5], 2'b00);
    send(8'h42, 0, 0, 0, 0, 0, 1);
    chk("R5 no reception", rx_valid, 1'b0);
    dcd_n = 1'b0;
    wr_ctl(8'h40);
    send(8'h42, 0, 0, 0, 0, 0, 1);
    expect_head("R5 carrier back", 8'h42, 4'b0000);

    // R4 io_stop clears fifo, overrun, enables
    for (int i = 0; i < 4; i++) send(8'h20, 0, 0, 0, 0, 0, 1);
    chk("R4 overrun before stop", ovr_flag, 1'b1);
    @(negedge clk); io_stop = 1'b1;
    @(negedge clk);
    chk("R4 fifo empty", rx_valid, 1'b0);
    chk("R4 ovr cleared", ovr_flag, 1'b0);
    chk("R4 enables cleared", ctl_q[6:5], 2'b00);
    wr_ctl(8'h60);
    chk("R4 enables held off", ctl_q[6:5], 2'b00);
    io_stop = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule